// File: doc/BRIEF.md
# In-Band Packet-End Escape Encoder

This block takes a 64-bit streaming input that carries a packet-end marker as a sideband bit and produces a 64-bit output stream with no such bit. Packet ends are encoded inside the data itself. A fixed escape word opens a three-word group: the escape word, then a flag word, then the original data word. The flag word's bit 0 says whether the data word ends a packet. Data words that happen to equal the escape value are also sent as a group, so the receiver never mistakes them for an escape. All other words pass through in the same cycle, with the handshake wired straight through.

While a group is being sent, the block holds its input ready low. The input word is accepted only when the last word of its group is handed off downstream. An optional running checksum can be enabled. It is the XOR of the two 32-bit halves of every word in the packet that comes before the final word, and it travels in bits 63:32 of the flag word that marks the packet end. A synchronous clear drops any group in progress and zeroes the checksum. Upstream still holds its word, so that word is then encoded again from the start.

Top module: `tlast_escape_encoder`

## Requirements
- R1: A word with sLast low whose value differs from the escape word 0xDEADBEEFFEEDCAFE leaves as one output word, unchanged, in the same cycle. mValid follows sValid, and sReady follows mReady.
- R2: A word with sLast high leaves as three words in this order: the escape word, then a flag word with bits 31:0 equal to 1, then the data word.
- R3: A word equal to the escape value with sLast low leaves as the escape word, then a flag word with bits 31:0 equal to 0, then the escape value as data.
- R4: A word equal to the escape value with sLast high leaves as the escape word, then a flag word with bits 31:0 equal to 1, then the escape value as data.
- R5: sReady is low while the escape word and the flag word are offered. The input word is accepted only in the cycle in which the last word of its group completes a handshake on the output.
- R6: With CSUM_EN=1, bits 63:32 of a flag word that marks a packet end equal the XOR of bits 63:32 and bits 31:0 of every earlier accepted word of that packet.
- R7: The checksum returns to zero after a packet's final word is accepted, and also on reset or clear.
- R8: Bits 63:32 of the flag word are zero when CSUM_EN=0, and also in any flag word whose bit 0 is 0.
- R9: While mValid is high and mReady is low, mValid stays high and mData stays unchanged in the next cycle, unless clear is asserted.
- R10: During a cycle with clear high, mValid and sReady are low. Afterwards the encoder is back in pass-through and encodes the held input word from its first output word.
- R11: After reset, with no input offered, mValid is low and sReady equals mReady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Synchronous clear of the group state and the checksum |
| sData | input | 64 | Input data word |
| sValid | input | 1 | Input word offered |
| sLast | input | 1 | Input word ends a packet |
| sReady | output | 1 | Input word accepted when high together with sValid |
| mData | output | 64 | Output word |
| mValid | output | 1 | Output word offered |
| mReady | input | 1 | Downstream accepts the output word |

## Verification
Two things can land in one cycle: the checksum update when a packet's final word is accepted, and the start of the next group. They can also collide with a clear that arrives partway through a group. The bench feeds back-to-back packets with escape-valued words and random stalls on both sides, and raises clear at random cycles. A flag word offered just after a packet end must then carry a checksum that starts from zero, and a word that was cut off by a clear must start again at its escape word. Both are judged against a behavioural model that rebuilds each word's expected group and checksum from the accepted inputs, and compares every clock.

// File: rtl/esc_enc_pkg.sv
package esc_enc_pkg;
  localparam int DATA_W = 64;
  localparam int HALF_W = DATA_W / 2;

  typedef enum logic [1:0] {
    PH_PASS,
    PH_FLAG,
    PH_DATA
  } phase_t;

  typedef enum logic [1:0] {
    SEL_IN,
    SEL_ESC,
    SEL_FLAG
  } outSel_t;

  typedef struct packed {
    outSel_t sel;
    logic    consume;
    logic    pktEnd;
  } encStrobe_t;
endpackage

// File: rtl/esc_enc_ctrl.sv
module esc_enc_ctrl
  import esc_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       sValid,
  input  logic       sLast,
  input  logic       matchEsc,
  input  logic       mReady,
  output logic       sReady,
  output logic       mValid,
  output encStrobe_t strb
);
  phase_t phase, phaseNext;
  logic   needGroup;
  logic   rawReady, rawValid;

  assign needGroup = sLast | matchEsc;

  always_comb begin
    phaseNext = phase;
    strb.sel  = SEL_IN;
    rawValid  = sValid;
    rawReady  = mReady;
    unique case (phase)
      PH_PASS: begin
        if (sValid && needGroup) begin
          strb.sel = SEL_ESC;
          rawReady = 1'b0;
          if (mReady) phaseNext = PH_FLAG;
        end
      end
      PH_FLAG: begin
        strb.sel = SEL_FLAG;
        rawReady = 1'b0;
        if (sValid && mReady) phaseNext = PH_DATA;
      end
      PH_DATA: begin
        if (sValid && mReady) phaseNext = PH_PASS;
      end
      default: phaseNext = PH_PASS;
    endcase
  end

  assign sReady       = rawReady & ~clear;
  assign mValid       = rawValid & ~clear;
  assign strb.consume = sValid & sReady;
  assign strb.pktEnd  = sLast;

  always_ff @(posedge clk) begin
    if (rst || clear) phase <= PH_PASS;
    else              phase <= phaseNext;
  end

  // R5: no input acceptance while the flag word is offered
  a_r5_hold_in_flag: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FLAG) |-> !sReady);

  // R2: an accepted escape word is followed by the flag word
  a_r2_esc_then_flag: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_PASS && mValid && mReady && !sReady) |=> (phase == PH_FLAG || clear));

  // R10: clear returns to pass-through
  a_r10_clear_to_pass: assert property (@(posedge clk) disable iff (rst)
    clear |=> (phase == PH_PASS));

  // R9: offered output word is not withdrawn
  a_r9_valid_hold: assert property (@(posedge clk) disable iff (rst || clear)
    (mValid && !mReady) |=> (mValid || clear));
endmodule

// File: rtl/esc_enc_dp.sv
module esc_enc_dp
  import esc_enc_pkg::*;
#(
  parameter logic [DATA_W-1:0] ESC_WORD = 64'hDEAD_BEEF_FEED_CAFE,
  parameter bit                CSUM_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic [DATA_W-1:0] sData,
  input  encStrobe_t        strb,
  output logic              matchEsc,
  output logic [DATA_W-1:0] mData
);
  logic [HALF_W-1:0] runSum;
  logic [HALF_W-1:0] flagHigh;
  logic [DATA_W-1:0] flagWord;

  assign matchEsc = (sData == ESC_WORD);

  generate
    if (CSUM_EN) begin : g_csum
      always_ff @(posedge clk) begin
        if (rst || clear)
          runSum <= '0;
        else if (strb.consume && strb.pktEnd)
          runSum <= '0;
        else if (strb.consume)
          runSum <= runSum ^ sData[DATA_W-1:HALF_W] ^ sData[HALF_W-1:0];
      end
      assign flagHigh = strb.pktEnd ? runSum : '0;
    end else begin : g_nocsum
      assign runSum   = '0;
      assign flagHigh = '0;
    end
  endgenerate

  assign flagWord = {flagHigh, {(HALF_W-1){1'b0}}, strb.pktEnd};

  always_comb begin
    unique case (strb.sel)
      SEL_ESC:  mData = ESC_WORD;
      SEL_FLAG: mData = flagWord;
      default:  mData = sData;
    endcase
  end

  // R7: checksum is zero after a packet's final word is accepted
  a_r7_sum_cleared: assert property (@(posedge clk) disable iff (rst)
    (strb.consume && strb.pktEnd) |=> (runSum == '0));

  // R8: escaped-data flag words carry no checksum
  a_r8_flag_high_zero: assert property (@(posedge clk) disable iff (rst)
    (strb.sel == SEL_FLAG && !strb.pktEnd) |-> (mData[DATA_W-1:HALF_W] == '0));
endmodule

// File: rtl/tlast_escape_encoder.sv
module tlast_escape_encoder
  import esc_enc_pkg::*;
#(
  parameter logic [63:0] ESC_WORD = 64'hDEAD_BEEF_FEED_CAFE,
  parameter bit          CSUM_EN  = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic [63:0] sData,
  input  logic        sValid,
  input  logic        sLast,
  output logic        sReady,
  output logic [63:0] mData,
  output logic        mValid,
  input  logic        mReady
);
  encStrobe_t strb;
  logic       matchEsc;

  esc_enc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .clear(clear),
    .sValid(sValid), .sLast(sLast), .matchEsc(matchEsc), .mReady(mReady),
    .sReady(sReady), .mValid(mValid), .strb(strb)
  );

  esc_enc_dp #(.ESC_WORD(ESC_WORD), .CSUM_EN(CSUM_EN)) u_dp (
    .clk(clk), .rst(rst), .clear(clear),
    .sData(sData), .strb(strb), .matchEsc(matchEsc), .mData(mData)
  );

  // R9: stalled output word keeps its value
  a_r9_data_stable: assert property (@(posedge clk) disable iff (rst || clear)
    (mValid && !mReady) |=> ($stable(mData) || clear));

  // R10: nothing moves during clear
  a_r10_clear_quiet: assert property (@(posedge clk) disable iff (rst)
    clear |-> (!mValid && !sReady));
endmodule

// File: tb/tb_tlast_escape_encoder.sv
module tb_tlast_escape_encoder;
  localparam logic [63:0] ESC = 64'hDEAD_BEEF_FEED_CAFE;

  logic clk = 1'b0;
  logic rst, clear, sValid, sLast, mReady;
  logic [63:0] sData;
  logic sReady, mValid, sReadyP, mValidP;
  logic [63:0] mData, mDataP;

  always #2 clk = ~clk;

  tlast_escape_encoder #(.ESC_WORD(ESC), .CSUM_EN(1'b1)) dut (
    .clk(clk), .rst(rst), .clear(clear), .sData(sData), .sValid(sValid),
    .sLast(sLast), .sReady(sReady), .mData(mData), .mValid(mValid), .mReady(mReady));

  tlast_escape_encoder #(.ESC_WORD(ESC), .CSUM_EN(1'b0)) dutPlain (
    .clk(clk), .rst(rst), .clear(clear), .sData(sData), .sValid(sValid),
    .sLast(sLast), .sReady(sReadyP), .mData(mDataP), .mValid(mValidP), .mReady(mReady));

  int nChecks = 0, nFails = 0;
  logic [64:0] srcQ[$];
  logic [63:0] curExp[$];
  int expIdx = 0;
  logic [31:0] modelSum = '0;
  logic held = 1'b0;
  logic [63:0] heldData;
  logic heldLast;
  logic prevS = 0, prevM = 0, prevClr = 0;
  int cyc = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  task automatic buildExp();
    curExp.delete();
    expIdx = 0;
    if (heldLast || heldData == ESC) begin
      curExp.push_back(ESC);
      curExp.push_back({heldLast ? modelSum : 32'h0, 31'h0, heldLast});
    end
    curExp.push_back(heldData);
  endtask

  function automatic string tagOf();
    if (curExp.size() == 1) return "R1";
    if (expIdx == 1) return heldLast ? "R2/R6" : "R3";
    if (heldData == ESC) return heldLast ? "R4" : "R3";
    return "R2";
  endfunction

  initial begin
    int limit;
    limit = 200000;
    repeat (limit) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    rst = 1; clear = 0; sValid = 0; sLast = 0; sData = '0; mReady = 1;
    for (int p = 0; p < 700; p++) begin
      int len;
      len = 1 + $urandom_range(0, 5);
      for (int w = 0; w < len; w++) begin
        logic [63:0] d;
        d = ($urandom_range(0, 4) == 0) ? ESC : {$urandom, $urandom};
        srcQ.push_back({(w == len - 1) ? 1'b1 : 1'b0, d});
      end
    end
    srcQ.push_back({1'b0, ESC});
    srcQ.push_back({1'b1, ESC});
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    // R11: idle after reset
    check(!mValid, "R11 mValid", {63'h0, mValid}, 64'h0);
    check(sReady == mReady, "R11 sReady", {63'h0, sReady}, {63'h0, mReady});
    mReady = 0;
    #1;
    check(sReady == 1'b0, "R11 sReady low", {63'h0, sReady}, 64'h0);
    while (!done) begin
      @(negedge clk);
      if (prevClr) begin
        modelSum = '0;  // R7 clear
        if (held) buildExp();
      end else begin
        if (prevM) expIdx++;
        if (prevS) begin
          if (heldLast) modelSum = '0;
          else modelSum = modelSum ^ heldData[63:32] ^ heldData[31:0];
          held = 0;
          curExp.delete();
          expIdx = 0;
        end
      end
      if (!held && srcQ.size() > 0 && $urandom_range(0, 9) < 7) begin
        logic [64:0] e;
        e = srcQ.pop_front();
        held = 1; heldData = e[63:0]; heldLast = e[64];
        buildExp();
      end
      sValid = held;
      sData  = held ? heldData : {$urandom, $urandom};
      sLast  = held ? heldLast : 1'b0;
      mReady = (cyc < 400) ? 1'b1 : ($urandom_range(0, 3) != 0);
      clear  = ($urandom_range(0, 299) == 0);
      #1;
      check(mValid == (held && !clear), prevClr ? "R10 mValid" : "R9 mValid",
            {63'h0, mValid}, {63'h0, held && !clear});
      if (held && !clear)
        check(sReady == (mReady && expIdx == curExp.size() - 1),
              prevClr ? "R10 sReady" : "R5 sReady", {63'h0, sReady},
              {63'h0, mReady && expIdx == curExp.size() - 1});
      if (clear)
        check(!sReady, "R10 sReady in clear", {63'h0, sReady}, 64'h0);
      if (mValid && expIdx < curExp.size()) begin
        logic [63:0] pe;
        check(mData == curExp[expIdx], tagOf(), mData, curExp[expIdx]);
        pe = curExp[expIdx];
        if (curExp.size() == 3 && expIdx == 1) pe[63:32] = '0;
        check(mDataP == pe, "R8 plain", mDataP, pe);
      end
      check(sReadyP == sReady && mValidP == mValid, "R8 plain handshake",
            {62'h0, sReadyP, mValidP}, {62'h0, sReady, mValid});
      prevS = sValid && sReady;
      prevM = mValid && mReady;
      prevClr = clear;
      if (!held && srcQ.size() == 0 && !prevClr) done = 1;
    end
    @(negedge clk);
    sValid = 0; clear = 0;
    repeat (5) @(negedge clk);
    #1;
    check(!mValid, "R11 drained", {63'h0, mValid}, 64'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule